// File: doc/BRIEF.md
# Secure Configuration Write-Lock Register Bank

This block holds five 32-bit secure configuration registers behind a coprocessor-style access port. Each access names a register with four fields: a primary number, a first opcode, a secondary number and a second opcode. It also carries a read/write flag, write data, the current processor mode and the non-secure state bit. The block answers every access strobe with exactly one registered response one cycle later. That response carries read data, a write-complete flag, or an undefined-instruction flag.

A hardware lock input lets the surrounding chip freeze the configuration once secure boot code has written it. After the lock is in force, writes to the five protected registers are refused and flagged as undefined instructions. Reads still return the stored values. The lock input first passes through a two-stage synchronizer. Its value reaches the effective lock only when a prefetch-flush pulse arrives, so a change on the pin affects only the accesses that follow the flush. The lock pin is low at reset, so every protected register can be written after reset.

Top module: `seccfg_lock`

## Requirements
- R1: After reset, all five protected registers read zero, the effective lock is 0, and `rsp_valid` is low until the first access.
- R2: The protected registers sit at these addresses, written as (primary, opcode1, secondary, opcode2): (1,0,0,0), (2,0,0,0), (2,0,0,2), (3,0,0,0) and (9,0,1,2). A legal write to one of them while the effective lock is 0 stores `acc_wdata`, sets `rsp_wack` and leaves `rsp_undef` low.
- R3: `rsp_valid` is high in the cycle after each cycle in which `acc_valid` is high, and low in every other cycle.
- R4: While the effective lock is 1, a write to a protected register leaves it unchanged and raises `rsp_undef`, with `rsp_wack` low.
- R5: While the effective lock is 1, a legal read of a protected register returns its contents, with `rsp_undef` low.
- R6: A new level on `lock_in` takes effect only at a `flush_pulse` edge, and only when the level has been stable for at least two clock edges before that flush. Accesses before the flush still see the old lock.
- R7: An access to a protected register is legal when `acc_mode` is monitor (5'h16), or when `acc_mode` is any mode other than user (5'h10) and `acc_ns` is 0. An illegal access raises `rsp_undef` whatever the lock value, does not write, and returns zero read data.
- R8: An access to any other address never raises `rsp_undef`. A read returns zero. A write changes no protected register and sets `rsp_wack`.
- R9: A write that is both locked and illegal produces a single response with `rsp_undef` high and `rsp_wack` low. `rsp_undef` and `rsp_wack` are never high together.
- R10: Each protected register is a full 32 bits wide and independent of the others. A write to one leaves the other four unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_crn | input | 4 | Primary register number |
| acc_op1 | input | 3 | First opcode field |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_mode | input | 5 | Current processor mode code |
| acc_ns | input | 1 | Non-secure state bit |
| lock_in | input | 1 | Asynchronous write-lock request from the chip |
| flush_pulse | input | 1 | Prefetch-flush pulse that loads the effective lock |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_rdata | output | 32 | Read data, zero unless a legal protected read |
| rsp_wack | output | 1 | Write completed |
| rsp_undef | output | 1 | Undefined-instruction response |

## Verification
The hardest case to reach is a register write that lands in the gap between a new `lock_in` level and the flush that makes it effective. In that gap the pin already reads 1 but the write must still succeed. The bench raises the pin, waits past the synchronizer delay without flushing, writes and reads back. It then flushes and retries the write, and later lowers the pin without a flush to show the lock stays in force. A write issued in user mode while locked is the combined case that must produce a single undefined response.

// File: rtl/seccfg_pkg.sv
package seccfg_pkg;

    localparam int N_PROT = 5;
    localparam int CRN_W  = 4;
    localparam int OP1_W  = 3;
    localparam int CRM_W  = 4;
    localparam int OP2_W  = 3;
    localparam int KEY_W  = CRN_W + OP1_W + CRM_W + OP2_W;
    localparam int MODE_W = 5;

    localparam logic [MODE_W-1:0] MODE_USER    = 5'h10;
    localparam logic [MODE_W-1:0] MODE_MONITOR = 5'h16;

    // Packed address key {primary, opcode1, secondary, opcode2} of protected slot idx
    function automatic logic [KEY_W-1:0] prot_key(input int idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = {4'd1, 3'd0, 4'd0, 3'd0};
            1:       k = {4'd2, 3'd0, 4'd0, 3'd0};
            2:       k = {4'd2, 3'd0, 4'd0, 3'd2};
            3:       k = {4'd3, 3'd0, 4'd0, 3'd0};
            default: k = {4'd9, 3'd0, 4'd1, 3'd2};
        endcase
        return k;
    endfunction

endpackage

// File: rtl/seccfg_lock_sync.sv
module seccfg_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    input  logic flush_pulse,
    output logic lock_eff
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              eff;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], lock_in};
        if (flush_pulse) begin
            s_d.eff = s_q.chain[STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_eff = s_q.eff;

    // R6
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_pulse |=> $stable(lock_eff));

endmodule

// File: rtl/seccfg_decode.sv
module seccfg_decode
    import seccfg_pkg::*;
(
    input  logic [CRN_W-1:0]  crn,
    input  logic [OP1_W-1:0]  op1,
    input  logic [CRM_W-1:0]  crm,
    input  logic [OP2_W-1:0]  op2,
    output logic [N_PROT-1:0] hit
);

    logic [KEY_W-1:0] key;
    assign key = {crn, op1, crm, op2};

    for (genvar g = 0; g < N_PROT; g++) begin : g_slot
        assign hit[g] = (key == prot_key(g));
    end

    // R2
    always_comb begin
        one_slot_chk: assert ($onehot0(hit));
    end

endmodule

// File: rtl/seccfg_lock.sv
module seccfg_lock
    import seccfg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [CRN_W-1:0]    acc_crn,
    input  logic [OP1_W-1:0]    acc_op1,
    input  logic [CRM_W-1:0]    acc_crm,
    input  logic [OP2_W-1:0]    acc_op2,
    input  logic                acc_write,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  logic [MODE_W-1:0]   acc_mode,
    input  logic                acc_ns,
    input  logic                lock_in,
    input  logic                flush_pulse,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_wack,
    output logic                rsp_undef
);

    typedef struct packed {
        logic [N_PROT-1:0][DATA_W-1:0] regs;
        logic                          valid;
        logic                          wack;
        logic                          undef;
        logic [DATA_W-1:0]             rdata;
    } bank_t;

    bank_t st_d, st_q;

    logic              lock_eff;
    logic [N_PROT-1:0] hit;
    logic              prot_hit;
    logic              legal;

    seccfg_lock_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_in     (lock_in),
        .flush_pulse (flush_pulse),
        .lock_eff    (lock_eff)
    );

    seccfg_decode i_decode (
        .crn (acc_crn),
        .op1 (acc_op1),
        .crm (acc_crm),
        .op2 (acc_op2),
        .hit (hit)
    );

    assign prot_hit = |hit;
    assign legal    = (acc_mode == MODE_MONITOR) ||
                      ((acc_mode != MODE_USER) && !acc_ns);

    always_comb begin
        st_d       = st_q;
        st_d.valid = acc_valid;
        st_d.wack  = 1'b0;
        st_d.undef = 1'b0;
        st_d.rdata = '0;
        if (acc_valid) begin
            if (prot_hit) begin
                if (!legal) begin
                    st_d.undef = 1'b1;
                end else if (acc_write) begin
                    if (lock_eff) begin
                        st_d.undef = 1'b1;
                    end else begin
                        for (int i = 0; i < N_PROT; i++) begin
                            if (hit[i]) st_d.regs[i] = acc_wdata;
                        end
                        st_d.wack = 1'b1;
                    end
                end else begin
                    for (int i = 0; i < N_PROT; i++) begin
                        if (hit[i]) st_d.rdata = st_d.rdata | st_q.regs[i];
                    end
                end
            end else if (acc_write) begin
                st_d.wack = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_rdata = st_q.rdata;
    assign rsp_wack  = st_q.wack;
    assign rsp_undef = st_q.undef;

    logic [N_PROT-1:0][DATA_W-1:0] bank_q;
    assign bank_q = st_q.regs;

    // R3
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    // R4
    locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && prot_hit && lock_eff) |=> ($stable(bank_q) && rsp_undef));

    // R7
    illegal_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && prot_hit && !legal) |=> (rsp_undef && rsp_rdata == '0));

    // R8
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !prot_hit) |=> (!rsp_undef && rsp_rdata == '0 && $stable(bank_q)));

    // R9
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_undef && rsp_wack));

    // R9
    undef_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> rsp_valid);

endmodule

// File: tb/test_seccfg_lock.sv
module test_seccfg_lock;

    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_SVC = 5'h13;
    localparam logic [4:0] M_MON = 5'h16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_crn = '0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [4:0]  acc_mode = M_SVC;
    logic        acc_ns = 1'b0;
    logic        lock_in = 1'b0;
    logic        flush_pulse = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_wack;
    logic        rsp_undef;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] model [5];
    logic        model_lock = 1'b0;

    logic [33:0] q_exp [$];
    string       q_tag [$];

    always #10ns clk = ~clk;

    seccfg_lock i_seccfg_lock (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid),
        .acc_crn (acc_crn), .acc_op1 (acc_op1), .acc_crm (acc_crm), .acc_op2 (acc_op2),
        .acc_write (acc_write), .acc_wdata (acc_wdata), .acc_mode (acc_mode), .acc_ns (acc_ns),
        .lock_in (lock_in), .flush_pulse (flush_pulse),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_wack (rsp_wack), .rsp_undef (rsp_undef)
    );

    function automatic int slot_of(input logic [3:0] n, input logic [2:0] a,
                                   input logic [3:0] m, input logic [2:0] b);
        if (a != 0) return -1;
        if (n == 1 && m == 0 && b == 0) return 0;
        if (n == 2 && m == 0 && b == 0) return 1;
        if (n == 2 && m == 0 && b == 2) return 2;
        if (n == 3 && m == 0 && b == 0) return 3;
        if (n == 9 && m == 1 && b == 2) return 4;
        return -1;
    endfunction

    function automatic logic [3:0] crn_of(input int s);
        case (s) 0: return 4'd1; 1: return 4'd2; 2: return 4'd2; 3: return 4'd3; default: return 4'd9; endcase
    endfunction
    function automatic logic [3:0] crm_of(input int s);
        return (s == 4) ? 4'd1 : 4'd0;
    endfunction
    function automatic logic [2:0] op2_of(input int s);
        return (s == 2 || s == 4) ? 3'd2 : 3'd0;
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got undef=%0b wack=%0b rdata=%h, expected undef=%0b wack=%0b rdata=%h",
                     tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Driver: one access, expected response pushed to the scoreboard
    task automatic access(input string tag, input logic [3:0] n, input logic [2:0] a,
                          input logic [3:0] m, input logic [2:0] b, input logic wr,
                          input logic [31:0] data, input logic [4:0] mode, input logic ns);
        int          s;
        bit          ok;
        logic [33:0] e;
        @(negedge clk);
        acc_valid = 1'b1; acc_crn = n; acc_op1 = a; acc_crm = m; acc_op2 = b;
        acc_write = wr; acc_wdata = data; acc_mode = mode; acc_ns = ns;
        s  = slot_of(n, a, m, b);
        ok = (mode == M_MON) || (mode != M_USR && ns == 1'b0);
        e  = '0;
        if (s < 0) begin
            e[32] = wr;
        end else if (!ok) begin
            e[33] = 1'b1;
        end else if (wr) begin
            if (model_lock) e[33] = 1'b1;
            else begin e[32] = 1'b1; model[s] = data; end
        end else begin
            e[31:0] = model[s];
        end
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic prot(input string tag, input int s, input logic wr, input logic [31:0] d,
                        input logic [4:0] mode, input logic ns);
        access(tag, crn_of(s), 3'd0, crm_of(s), op2_of(s), wr, d, mode, ns);
    endtask

    task automatic set_lock(input logic v, input bit do_flush);
        @(negedge clk);
        lock_in = v;
        repeat (3) @(negedge clk);
        if (do_flush) begin
            flush_pulse = 1'b1;
            @(negedge clk);
            flush_pulse = 1'b0;
            model_lock = v;
        end
    endtask

    // Monitor: compare each response with the scoreboard, one step after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            if (rst_n && !done) begin
                if (q_exp.size() > 0) begin
                    logic [33:0] e;
                    string       t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    if (!rsp_valid) begin
                        n_checks++; n_fails++;
                        $display("FAIL R3 (%s): rsp_valid=0, expected 1", t);
                    end else begin
                        check(t, {rsp_undef, rsp_wack, rsp_rdata}, e);
                    end
                end else if (rsp_valid) begin
                    n_checks++; n_fails++;
                    $display("FAIL R3: rsp_valid=1 with no access, expected 0");
                end
            end
        end
    end

    initial begin
        #4ms;
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: idle output and cleared bank
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: rsp_valid=%0b after reset, expected 0", rsp_valid);
        end
        for (int s = 0; s < 5; s++) prot("R1", s, 1'b0, '0, M_SVC, 1'b0);

        // R2 / R10: write each slot with distinct data, then read all back
        for (int s = 0; s < 5; s++) prot("R2", s, 1'b1, 32'hA5A5_0000 ^ (32'h1111_1111 * (s + 1)), M_SVC, 1'b0);
        for (int s = 0; s < 5; s++) prot("R10", s, 1'b0, '0, M_SVC, 1'b0);
        prot("R10", 3, 1'b1, 32'hFFFF_FFFF, M_SVC, 1'b0);
        for (int s = 0; s < 5; s++) prot("R10", s, 1'b0, '0, M_SVC, 1'b0);

        // R7: monitor with NS=1 is legal; user or NS=1 privileged is not
        prot("R7", 0, 1'b1, 32'h1234_5678, M_MON, 1'b1);
        prot("R7", 0, 1'b0, '0, M_MON, 1'b1);
        prot("R7", 1, 1'b1, 32'hDEAD_BEEF, M_USR, 1'b0);
        prot("R7", 1, 1'b0, '0, M_USR, 1'b0);
        prot("R7", 2, 1'b1, 32'h0BAD_0BAD, M_SVC, 1'b1);
        prot("R7", 2, 1'b0, '0, M_SVC, 1'b1);
        prot("R7", 1, 1'b0, '0, M_SVC, 1'b0);
        prot("R7", 2, 1'b0, '0, M_SVC, 1'b0);

        // R8: addresses outside the set
        access("R8", 4'd2, 3'd0, 4'd0, 3'd1, 1'b1, 32'hCAFE_F00D, M_SVC, 1'b0);
        access("R8", 4'd2, 3'd0, 4'd0, 3'd1, 1'b0, '0, M_SVC, 1'b0);
        access("R8", 4'd1, 3'd1, 4'd0, 3'd0, 1'b1, 32'h7777_7777, M_USR, 1'b1);
        access("R8", 4'd9, 3'd0, 4'd1, 3'd1, 1'b0, '0, M_USR, 1'b0);
        for (int s = 0; s < 5; s++) prot("R8", s, 1'b0, '0, M_SVC, 1'b0);

        // R6: pin high, no flush yet, writes still land
        set_lock(1'b1, 1'b0);
        prot("R6", 1, 1'b1, 32'h5555_AAAA, M_SVC, 1'b0);
        prot("R6", 1, 1'b0, '0, M_SVC, 1'b0);

        // R4 / R5 / R9: after flush the bank is frozen
        set_lock(1'b1, 1'b1);
        for (int s = 0; s < 5; s++) prot("R4", s, 1'b1, 32'h0000_0001 << s, M_SVC, 1'b0);
        prot("R4", 0, 1'b1, 32'h0F0F_0F0F, M_MON, 1'b1);
        for (int s = 0; s < 5; s++) prot("R5", s, 1'b0, '0, M_SVC, 1'b0);
        prot("R9", 3, 1'b1, 32'h9999_9999, M_USR, 1'b0);
        prot("R9", 3, 1'b0, '0, M_SVC, 1'b0);
        access("R8", 4'd3, 3'd0, 4'd0, 3'd1, 1'b1, 32'h1, M_SVC, 1'b0);

        // R6: pin low without flush keeps the lock; flush releases it
        set_lock(1'b0, 1'b0);
        prot("R6", 2, 1'b1, 32'h2468_ACE0, M_SVC, 1'b0);
        prot("R6", 2, 1'b0, '0, M_SVC, 1'b0);
        set_lock(1'b0, 1'b1);
        prot("R6", 2, 1'b1, 32'h2468_ACE0, M_SVC, 1'b0);
        prot("R6", 2, 1'b0, '0, M_SVC, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        if (q_exp.size() != 0) begin
            n_checks++; n_fails++;
            $display("FAIL R3: %0d responses missing, expected 0", q_exp.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule